// File: doc/BRIEF.md
# Flash Fetch Benchmark Counter Unit

This unit counts how often the flash array is accessed so that software can profile the power cost of a running application. It keeps two free-running counters. One advances on each instruction-fetch strobe from the flash access path. The other advances on each data-fetch strobe. Software can read and overwrite either counter through a small register interface. Writes take effect at the next clock edge, and reads are combinational from the register address.

One compare channel watches one of the two counters, picked by a select bit. It raises a sticky match flag at the moment an increment brings the watched counter onto the programmed compare value. That flag sits in a four-bit flag register alongside three status events from the rest of the flash controller: program error, erase done and burst-compare done. Each flag has its own enable bit. A single interrupt line is driven high while any enabled flag is set. Flags stay set until software clears them by writing ones.

Top module: `fetch_bench_unit`

## Requirements
- R1: After reset, both counters, the compare value, the select bit, the flag register and the enable register read as zero, and `irq` is low.
- R2: While `ifetch_stb` is high, the instruction counter rises by one on each clock edge; while `dfetch_stb` is high, the data counter rises by one on each clock edge.
- R3: When both strobes are high in the same cycle, both counters advance in that cycle.
- R4: Register addresses: 0 instruction counter, 1 data counter, 2 compare value, 3 select (bit 0: 0 watches the instruction counter, 1 the data counter), 4 flags, 5 enables; values written to 0, 1, 2, 3 and 5 read back unchanged, and addresses 6 and 7 read as zero.
- R5: A register write to a counter in the same cycle as that counter's strobe loads the written value, and the increment is lost.
- R6: The match flag (flag bit 3) sets on the clock edge at which a strobe increments the selected counter to a value equal to the compare value.
- R7: Writing a counter or the compare value so that they become equal does not set the match flag.
- R8: Increments of the counter that is not selected never set the match flag.
- R9: Counters wrap from all ones to zero; the wrap raises no event unless the compare value is zero and the wrapping counter is selected.
- R10: Pulses on `prog_err_evt`, `erase_done_evt` and `burst_done_evt` set flag bits 0, 1 and 2; every flag stays set until it is cleared.
- R11: `irq` is high exactly while some flag bit is set and the enable bit at the same position is set.
- R12: Writing to address 4 clears each flag whose data bit is 1; flags at positions written 0 are unchanged.
- R13: A flag whose set event and clear arrive in the same cycle ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| ifetch_stb | input | 1 | One-cycle pulse per instruction fetch from flash |
| dfetch_stb | input | 1 | One-cycle pulse per data fetch from flash |
| prog_err_evt | input | 1 | Program-error event pulse |
| erase_done_evt | input | 1 | Erase-complete event pulse |
| burst_done_evt | input | 1 | Burst read/compare complete event pulse |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wen | input | 1 | Register write enable |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data for reg_addr |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is the point where the counter and the compare value become equal without an increment. This happens when software loads a counter, or the compare value, onto the other's current value. The stimulus reaches it by first raising and clearing a true match. It then writes the compare value to the counter's current value, and next writes a counter directly onto a fresh compare value. Both writes must leave the flag clear. A strobe is also driven in the same cycle as a counter write. Wrap-around is reached by loading a counter with all ones instead of counting up to it. The collision of a set event with a clear in the same cycle is produced by pulsing an event input while the flag register is written.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int CNT_W  = 32;
  localparam int ADDR_W = 3;
  localparam int NFLAG  = 4;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_ICNT = 3'd0,
    ADDR_DCNT = 3'd1,
    ADDR_CMP  = 3'd2,
    ADDR_SEL  = 3'd3,
    ADDR_FLAG = 3'd4,
    ADDR_EN   = 3'd5
  } reg_addr_e;

  localparam int FLG_PROG  = 0;
  localparam int FLG_ERASE = 1;
  localparam int FLG_BURST = 2;
  localparam int FLG_MATCH = 3;
endpackage

// File: rtl/fb_counter.sv
module fb_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         inc,
  output logic [W-1:0] cnt_q,
  output logic         inc_fire
);
  logic [W-1:0] cnt_d;
  logic         cnt_ce;

  always_comb begin
    inc_fire = inc & ~wr_en;
    cnt_ce   = wr_en | inc;
    if (wr_en)    cnt_d = wr_data;
    else if (inc) cnt_d = cnt_q + W'(1);
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R5
  cnt_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cnt_q == $past(wr_data));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_en) |=> cnt_q == $past(cnt_q) + W'(1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr_en) |=> $stable(cnt_q));
endmodule

// File: rtl/fb_match.sv
module fb_match #(
  parameter int W = 32
) (
  input  logic [W-1:0] cnt_i,
  input  logic         fire_i,
  input  logic [W-1:0] cnt_d,
  input  logic         fire_d,
  input  logic         sel,
  input  logic [W-1:0] cmp,
  output logic         hit
);
  logic [W-1:0] watch_cnt;
  logic         watch_fire;

  always_comb begin
    watch_cnt  = sel ? cnt_d  : cnt_i;
    watch_fire = sel ? fire_d : fire_i;
    hit        = watch_fire && ((watch_cnt + W'(1)) == cmp);
  end
endmodule

// File: rtl/fb_flags.sv
module fb_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags_q,
  output logic         irq
);
  logic [N-1:0] flags_d;

  always_comb begin
    flags_d = (flags_q & ~clr_mask) | set_evt;
    irq     = |(flags_q & en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  for (genvar k = 0; k < N; k++) begin : g_flag_chk
    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[k] && !clr_mask[k]) |=> flags_q[k]);
    // R13
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[k] |=> flags_q[k]);
  end

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags_q != '0));
endmodule

// File: rtl/fetch_bench_unit.sv
module fetch_bench_unit
  import fb_pkg::*;
#(
  parameter int CNT_W = fb_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ifetch_stb,
  input  logic              dfetch_stb,
  input  logic              prog_err_evt,
  input  logic              erase_done_evt,
  input  logic              burst_done_evt,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq
);
  localparam int NCNT = 2;

  logic [NCNT-1:0]  cnt_wr;
  logic [NCNT-1:0]  cnt_inc;
  logic [NCNT-1:0]  cnt_fire;
  logic [CNT_W-1:0] cnt_val [NCNT];

  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             sel_q, sel_d;
  logic [NFLAG-1:0] en_q, en_d;
  logic             cfg_ce;

  logic             match_hit;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_clr;
  logic [NFLAG-1:0] flags_q;

  assign cnt_inc = {dfetch_stb, ifetch_stb};

  // Counters sit at addresses 0 .. NCNT-1 in fetch-kind order.
  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    assign cnt_wr[g] = reg_wen && (reg_addr == ADDR_W'(g));
    fb_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cnt_wr[g]),
      .wr_data  (reg_wdata),
      .inc      (cnt_inc[g]),
      .cnt_q    (cnt_val[g]),
      .inc_fire (cnt_fire[g])
    );
  end

  always_comb begin
    cmp_d  = cmp_q;
    sel_d  = sel_q;
    en_d   = en_q;
    cfg_ce = 1'b0;
    if (reg_wen) begin
      unique case (reg_addr)
        ADDR_CMP: begin cmp_d = reg_wdata;            cfg_ce = 1'b1; end
        ADDR_SEL: begin sel_d = reg_wdata[0];         cfg_ce = 1'b1; end
        ADDR_EN:  begin en_d  = reg_wdata[NFLAG-1:0]; cfg_ce = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      sel_q <= 1'b0;
      en_q  <= '0;
    end else if (cfg_ce) begin
      cmp_q <= cmp_d;
      sel_q <= sel_d;
      en_q  <= en_d;
    end
  end

  fb_match #(.W(CNT_W)) u_match (
    .cnt_i  (cnt_val[0]),
    .fire_i (cnt_fire[0]),
    .cnt_d  (cnt_val[1]),
    .fire_d (cnt_fire[1]),
    .sel    (sel_q),
    .cmp    (cmp_q),
    .hit    (match_hit)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLG_PROG]  = prog_err_evt;
    flag_set[FLG_ERASE] = erase_done_evt;
    flag_set[FLG_BURST] = burst_done_evt;
    flag_set[FLG_MATCH] = match_hit;
    flag_clr = (reg_wen && reg_addr == ADDR_FLAG) ? reg_wdata[NFLAG-1:0] : '0;
  end

  fb_flags #(.N(NFLAG)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (flag_set),
    .clr_mask (flag_clr),
    .en       (en_q),
    .flags_q  (flags_q),
    .irq      (irq)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_ICNT: reg_rdata = cnt_val[0];
      ADDR_DCNT: reg_rdata = cnt_val[1];
      ADDR_CMP:  reg_rdata = cmp_q;
      ADDR_SEL:  reg_rdata[0] = sel_q;
      ADDR_FLAG: reg_rdata[NFLAG-1:0] = flags_q;
      ADDR_EN:   reg_rdata[NFLAG-1:0] = en_q;
      default:   reg_rdata = '0;
    endcase
  end

  // R6
  match_on_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[FLG_MATCH]) |-> ((sel_q ? cnt_val[1] : cnt_val[0]) == $past(cmp_q)));

  // R7
  match_not_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[FLG_MATCH]) |-> !$past(cnt_wr[sel_q]));

  // R8
  match_needs_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[FLG_MATCH]) |-> $past(sel_q ? cnt_fire[1] : cnt_fire[0]));
endmodule

// File: tb/tb_fetch_bench_unit.sv
`timescale 1ns/100ps
module tb_fetch_bench_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ifetch_stb, dfetch_stb;
  logic         prog_err_evt, erase_done_evt, burst_done_evt;
  logic [2:0]   reg_addr;
  logic         reg_wen;
  logic [W-1:0] reg_wdata;
  logic [W-1:0] reg_rdata;
  logic         irq;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 1'b0;

  logic [2:0]   q_addr [$];
  logic [W-1:0] q_data [$];
  logic         q_irq  [$];
  string        q_tag  [$];

  always #2.5 clk = ~clk;

  fetch_bench_unit dut (
    .clk(clk), .rst_n(rst_n),
    .ifetch_stb(ifetch_stb), .dfetch_stb(dfetch_stb),
    .prog_err_evt(prog_err_evt), .erase_done_evt(erase_done_evt),
    .burst_done_evt(burst_done_evt),
    .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // Driver side: place the address and queue the expected item.
  task automatic expect_reg(input logic [2:0] a, input logic [W-1:0] d,
                            input logic ei, input string tag);
    @(negedge clk);
    reg_addr = a;
    q_addr.push_back(a);
    q_data.push_back(d);
    q_irq.push_back(ei);
    q_tag.push_back(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic pulse(input logic i, input logic d, input int n);
    @(negedge clk);
    ifetch_stb = i; dfetch_stb = d;
    repeat (n) @(negedge clk);
    ifetch_stb = 1'b0; dfetch_stb = 1'b0;
  endtask

  task automatic evt(input logic p, input logic e, input logic b);
    @(negedge clk);
    prog_err_evt = p; erase_done_evt = e; burst_done_evt = b;
    @(negedge clk);
    prog_err_evt = 1'b0; erase_done_evt = 1'b0; burst_done_evt = 1'b0;
  endtask

  // Monitor: pop items and compare against the outputs.
  initial begin
    forever begin
      wait (q_addr.size() > 0);
      #1;
      tests_run++;
      if (reg_rdata !== q_data[0] || irq !== q_irq[0]) begin
        tests_failed++;
        $display("FAIL %s addr=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
                 q_tag[0], q_addr[0], reg_rdata, irq, q_data[0], q_irq[0]);
      end
      void'(q_addr.pop_front());
      void'(q_data.pop_front());
      void'(q_irq.pop_front());
      void'(q_tag.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ifetch_stb = 0; dfetch_stb = 0;
    prog_err_evt = 0; erase_done_evt = 0; burst_done_evt = 0;
    reg_addr = '0; reg_wen = 0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) expect_reg(3'(a), '0, 1'b0, "R1");

    // R2 single strobes
    pulse(1, 0, 5);
    expect_reg(0, 5, 0, "R2");
    pulse(0, 1, 3);
    expect_reg(1, 3, 0, "R2");
    // R3 both strobes together
    pulse(1, 1, 4);
    expect_reg(0, 9, 0, "R3");
    expect_reg(1, 7, 0, "R3");

    // R4 counter write / readback
    wr(0, 100);
    expect_reg(0, 100, 0, "R4");
    // R5 write with same-cycle strobe
    @(negedge clk);
    reg_wen = 1; reg_addr = 1; reg_wdata = 50; dfetch_stb = 1;
    @(negedge clk);
    reg_wen = 0; dfetch_stb = 0;
    expect_reg(1, 50, 0, "R5");

    // R6 match on instruction counter
    wr(3, 0); wr(2, 103); wr(5, 32'h8);
    pulse(1, 0, 2);
    expect_reg(4, 0, 0, "R6");
    pulse(1, 0, 1);
    expect_reg(0, 103, 1, "R6");
    expect_reg(4, 32'h8, 1, "R6");
    pulse(1, 0, 2);
    expect_reg(4, 32'h8, 1, "R10");
    // R12 zero bits leave the flag alone
    wr(4, 32'h7);
    expect_reg(4, 32'h8, 1, "R12");
    wr(4, 32'h8);
    expect_reg(4, 0, 0, "R12");

    // R7 equality by software write
    wr(2, 105);
    expect_reg(4, 0, 0, "R7");
    wr(2, 300); wr(0, 300);
    expect_reg(4, 0, 0, "R7");

    // R8 unselected counter ignored
    wr(3, 1); wr(2, 52);
    wr(0, 47);
    pulse(1, 0, 5);
    expect_reg(0, 52, 0, "R8");
    expect_reg(4, 0, 0, "R8");
    pulse(0, 1, 2);
    expect_reg(4, 32'h8, 1, "R6");
    wr(4, 32'h8);

    // R9 wrap without event
    wr(2, 5); wr(1, 32'hFFFF_FFFF);
    pulse(0, 1, 1);
    expect_reg(1, 0, 0, "R9");
    expect_reg(4, 0, 0, "R9");
    // R9 wrap onto compare zero
    wr(2, 0); wr(1, 32'hFFFF_FFFF);
    pulse(0, 1, 1);
    expect_reg(4, 32'h8, 1, "R9");
    wr(4, 32'h8);

    // R10 event flags, R11 gating
    wr(5, 0);
    evt(1, 0, 0); evt(0, 1, 0); evt(0, 0, 1);
    expect_reg(4, 32'h7, 0, "R10");
    wr(5, 32'h2);
    expect_reg(4, 32'h7, 1, "R11");
    wr(4, 32'h2);
    expect_reg(4, 32'h5, 0, "R12");
    wr(5, 32'h5);
    expect_reg(4, 32'h5, 1, "R11");

    // R13 set and clear in one cycle
    @(negedge clk);
    reg_wen = 1; reg_addr = 4; reg_wdata = 32'h2; erase_done_evt = 1;
    @(negedge clk);
    reg_wen = 0; erase_done_evt = 0;
    expect_reg(4, 32'h7, 1, "R13");

    // R4 configuration readback and unmapped addresses
    expect_reg(3, 1, 1, "R4");
    expect_reg(5, 32'h5, 1, "R4");
    expect_reg(2, 0, 1, "R4");
    expect_reg(6, 0, 1, "R4");
    expect_reg(7, 0, 1, "R4");

    wait (q_addr.size() == 0);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule